// File: doc/BRIEF.md
# Banked TLB Special-Register Port

This block is the special-register window that software uses to maintain a small, software-managed translation buffer. The buffer holds two MMU banks. Each bank has 4 sets of 16 entries, and each entry is a 64-bit pair made of a high word and a low word. Software picks a special-register bank with a 4-bit bank select, and only the low two bits of that select are decoded. Software then reads or writes special registers by index through single-cycle strobes.

An entry is never written directly. Software first loads the select register with the set and entry index. It then writes the high register, which also loads the cause register. Finally it writes the low register, which commits the entry: the low word is the written data and the high word is taken from the cause register. If the entry being replaced was valid, the block pulses an invalidate in the same cycle, carrying the old page address. A read strobe refreshes the high and low mirror registers from the selected entry, and the requested register is returned one cycle later.

A separate process-ID port tracks the current ID and raises a flush request when software changes it.

Top module: `tlb_sreg_port`

## Requirements
- R1: After reset, every entry and the select, high, low, cause and current-ID registers are zero. While reset is held and at release, `rdata_o` is zero and `inv_o` and `flush_o` are low.
- R2: Only `bank_i[1:0]` is decoded. The value 1 selects MMU bank 0 and the value 2 selects MMU bank 1. With 0 or 3, writes change no register or entry and raise no invalidate, and reads return zero.
- R3: A write to index 6 (high) in an MMU bank loads the data into both the high register and the cause register (index 3, read-only).
- R4: A write to index 4 stores the full 32-bit select word, and a read of index 4 returns it. Bits 5:4 of that word pick the set and bits 3:0 pick the entry. No other bits affect entry addressing, and the select changes only on such a write.
- R5: A write to index 5 (low) in an MMU bank loads the low register and commits the selected entry in the selected MMU bank. The entry's low word becomes the data and its high word becomes the current cause value.
- R6: On a commit where the replaced entry has low-word bit 3 set, `inv_o` is high in the same cycle as the strobe. In that case `inv_addr_o` equals the old high word with bits 12:0 cleared. A commit over an entry with bit 3 clear, and any other write, leaves `inv_o` low.
- R7: A read strobe in an MMU bank copies the selected entry into the high and low registers. In the next cycle `rdata_o` holds the requested register after that copy: index 3 gives cause, 4 gives select, 5 gives low, 6 gives high, and any other index gives zero.
- R8: A write on the ID port compares `pid_i[7:0]` with the current ID. If they differ, `flush_o` is high in that cycle and `flush_pid_o` shows the current ID. The current ID then becomes `pid_i[7:0]`.
- R9: When the read and write strobes are both high, the write takes effect and the read is dropped, so `rdata_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | 4 | Special-register bank select; low two bits decoded |
| sreg_i | input | 4 | Special-register index |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| inv_o | output | 1 | Invalidate pulse for a replaced valid entry |
| inv_addr_o | output | 32 | Page address of the replaced entry |
| pid_wr_i | input | 1 | Process-ID update strobe |
| pid_i | input | 32 | New process ID; low 8 bits used |
| flush_o | output | 1 | Flush request on an ID change |
| flush_pid_o | output | 8 | Current process ID, which tags the flush |

## Verification
The bench commits every entry in both MMU banks twice, and varies the valid bit between the two passes. This shows whether an invalidate follows the old entry's valid bit rather than the new one, and whether the page address comes from the old high word. A design that decoded the wrong bank, or dropped or mixed up the set field, would return another entry's words on read-back. Writes in the two non-MMU bank codes are followed by reads through an MMU bank; a design that let them through would show a changed cause or entry. A same-cycle read and write, and process-ID writes whose low byte is unchanged but whose upper bits differ, catch a wrong strobe priority and a compare that uses too many bits.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_REG_W = 4;

  typedef enum logic [IDX_REG_W-1:0] {
    SR_CAUSE = 4'd3,
    SR_SEL   = 4'd4,
    SR_LO    = 4'd5,
    SR_HI    = 4'd6
  } sreg_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } tlb_word_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_sreg_pkg::*;
#(
  parameter int unsigned N_BANKS = 2,
  parameter int unsigned DEPTH   = 64,
  localparam int unsigned BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  tlb_word_t         wdata_i,
  output tlb_word_t         rdata_o
);
  tlb_word_t bank_rd [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    tlb_word_t mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i && (bank_i == BANK_W'(b))) begin
        mem_q[addr_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = mem_q[addr_i];
  end

  assign rdata_o = bank_rd[bank_i];

  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i) || !$stable(addr_i) || !$stable(bank_i)); // R5
endmodule

// File: rtl/tlb_pid_track.sv
module tlb_pid_track #(
  parameter int unsigned PID_W = 8,
  parameter int unsigned IN_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pid_wr_i,
  input  logic [IN_W-1:0]  pid_i,
  output logic             flush_o,
  output logic [PID_W-1:0] flush_pid_o
);
  logic [PID_W-1:0] cur_q;
  logic [PID_W-1:0] new_pid;

  assign new_pid = pid_i[PID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (pid_wr_i) cur_q <= new_pid;
  end

  assign flush_o     = pid_wr_i && (new_pid != cur_q);
  assign flush_pid_o = cur_q;

  AST_PID_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_wr_i |=> flush_pid_o == $past(pid_i[PID_W-1:0])); // R8
  AST_PID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pid_wr_i |=> $stable(flush_pid_o)); // R8
endmodule

// File: rtl/tlb_sreg_port.sv
module tlb_sreg_port
  import tlb_sreg_pkg::*;
#(
  parameter int unsigned N_SETS     = 4,
  parameter int unsigned N_ENTRIES  = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned VALID_BIT  = 3,
  parameter int unsigned PID_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        bank_i,
  input  logic [3:0]        sreg_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              inv_o,
  output logic [31:0]       inv_addr_o,
  input  logic              pid_wr_i,
  input  logic [31:0]       pid_i,
  output logic              flush_o,
  output logic [PID_W-1:0]  flush_pid_o
);
  localparam int unsigned N_BANKS = 2;
  localparam int unsigned IDX_W   = $clog2(N_ENTRIES);
  localparam int unsigned SET_W   = $clog2(N_SETS);
  localparam int unsigned ADDR_W  = IDX_W + SET_W;
  localparam int unsigned DEPTH   = N_SETS * N_ENTRIES;

  logic [WORD_W-1:0] sel_q, hi_q, lo_q, cause_q;
  logic [1:0]        bank_code;
  logic              mmu_bank;
  logic              tlb_bank;
  logic [ADDR_W-1:0] ent_addr;
  logic              wr_act, rd_act, commit;
  tlb_word_t         ent_rd, ent_wr;
  logic [WORD_W-1:0] rd_mux;

  assign bank_code = bank_i[1:0];
  assign mmu_bank  = (bank_code == 2'd1) || (bank_code == 2'd2);
  assign tlb_bank  = (bank_code == 2'd2);
  assign ent_addr  = {sel_q[IDX_W +: SET_W], sel_q[IDX_W-1:0]};

  assign wr_act = wr_i && mmu_bank;
  assign rd_act = rd_i && !wr_i && mmu_bank;
  assign commit = wr_act && (sreg_i == SR_LO);

  assign ent_wr.lo = wdata_i;
  assign ent_wr.hi = cause_q;

  tlb_entry_store #(
    .N_BANKS (N_BANKS),
    .DEPTH   (DEPTH)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .bank_i  (tlb_bank),
    .addr_i  (ent_addr),
    .wdata_i (ent_wr),
    .rdata_o (ent_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cause_q <= '0;
    end else if (wr_act) begin
      unique case (sreg_i)
        SR_SEL: sel_q <= wdata_i;
        SR_LO:  lo_q  <= wdata_i;
        SR_HI: begin
          hi_q    <= wdata_i;
          cause_q <= wdata_i;
        end
        default: ;
      endcase
    end else if (rd_act) begin
      hi_q <= ent_rd.hi;
      lo_q <= ent_rd.lo;
    end
  end

  // Read value reflects the mirror refresh done by this same strobe
  always_comb begin
    unique case (sreg_i)
      SR_CAUSE: rd_mux = cause_q;
      SR_SEL:   rd_mux = sel_q;
      SR_LO:    rd_mux = ent_rd.lo;
      SR_HI:    rd_mux = ent_rd.hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (rd_i && !wr_i)    rdata_o <= mmu_bank ? rd_mux : '0;
  end

  assign inv_o      = commit && ent_rd.lo[VALID_BIT];
  assign inv_addr_o = {ent_rd.hi[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  tlb_pid_track #(
    .PID_W (PID_W),
    .IN_W  (32)
  ) u_pid (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pid_wr_i    (pid_wr_i),
    .pid_i       (pid_i),
    .flush_o     (flush_o),
    .flush_pid_o (flush_pid_o)
  );

  AST_INV_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> wr_i && (bank_i[1:0] == 2'd1 || bank_i[1:0] == 2'd2) && sreg_i == 4'd5); // R6
  AST_INV_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> inv_addr_o[PAGE_SHIFT-1:0] == '0); // R6
  AST_NONMMU_NO_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i[1:0] == 2'd0 || bank_i[1:0] == 2'd3) |-> !inv_o); // R2
  AST_NONMMU_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && (bank_i[1:0] == 2'd0 || bank_i[1:0] == 2'd3)) |=> rdata_o == '0); // R2
  AST_HI_CAUSE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && sreg_i == 4'd6) |=> hi_q == cause_q); // R3
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sel_q)); // R4
  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(rdata_o)); // R9
endmodule

// File: tb/tlb_sreg_port_tb.sv
`timescale 1ns/1ps
module tlb_sreg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank = '0;
  logic [3:0]  sreg = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        inv;
  logic [31:0] inv_addr;
  logic        pid_wr = 1'b0;
  logic [31:0] pid = '0;
  logic        flush;
  logic [7:0]  flush_pid;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_hi [2][64];
  logic [31:0] m_lo [2][64];

  always #2.5 clk = ~clk;

  tlb_sreg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bank_i(bank), .sreg_i(sreg),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .inv_o(inv), .inv_addr_o(inv_addr), .pid_wr_i(pid_wr), .pid_i(pid),
    .flush_o(flush), .flush_pid_o(flush_pid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Write with same-cycle sampling of the invalidate outputs
  task automatic sreg_wr(input logic [3:0] b, input logic [3:0] idx, input logic [31:0] d,
                         output logic inv_s, output logic [31:0] addr_s);
    @(negedge clk);
    bank = b; sreg = idx; wdata = d; wr = 1'b1;
    #1;
    inv_s = inv; addr_s = inv_addr;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic sreg_rd(input logic [3:0] b, input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    bank = b; sreg = idx; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pid_write(input logic [31:0] v, output logic f, output logic [7:0] fp);
    @(negedge clk);
    pid = v; pid_wr = 1'b1;
    #1;
    f = flush; fp = flush_pid;
    @(posedge clk); #1;
    pid_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic        iv;
    logic [31:0] ia, rv;
    logic        fl;
    logic [7:0]  fp;
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 64; e++) begin m_hi[b][e] = '0; m_lo[b][e] = '0; end

    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 inv in reset", {31'h0, inv}, 32'h0);
    chk("R1 flush in reset", {31'h0, flush}, 32'h0);
    rst_n = 1'b1;
    sreg_rd(4'd1, 4'd5, rv);  chk("R1 entry lo after reset", rv, 32'h0);
    sreg_rd(4'd2, 4'd6, rv);  chk("R1 entry hi after reset", rv, 32'h0);
    sreg_rd(4'd1, 4'd4, rv);  chk("R1 select after reset", rv, 32'h0);
    sreg_rd(4'd1, 4'd3, rv);  chk("R1 cause after reset", rv, 32'h0);

    // Two passes over every entry of both MMU banks; valid bit flips between passes
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        for (int e = 0; e < 64; e++) begin
          logic [3:0]  bk;
          logic [31:0] sel, hv, lv;
          bk  = (b == 0) ? ((p == 0) ? 4'h5 : 4'h1) : ((p == 0) ? 4'hE : 4'h2);
          sel = 32'hABCD_0000 | (32'(p) << 8) | 32'(e) | 32'h0000_00C0;
          hv  = 32'h1357_9BDF ^ (32'(e) * 32'h0002_4681) ^ (32'(b) << 30) ^ (32'(p) << 20);
          lv  = (32'(e) * 32'h0000_0511) ^ (32'(p) << 16);
          lv[3] = e[0] ^ p[0] ^ b[0];
          sreg_wr(bk, 4'd4, sel, iv, ia);
          chk("R6 no inv on select write", {31'h0, iv}, 32'h0);
          sreg_wr(bk, 4'd6, hv, iv, ia);
          chk("R6 no inv on high write", {31'h0, iv}, 32'h0);
          sreg_wr(bk, 4'd5, lv, iv, ia);
          chk("R6 inv follows old valid", {31'h0, iv}, {31'h0, m_lo[b][e][3]});
          if (m_lo[b][e][3])
            chk("R6 inv page address", ia, {m_hi[b][e][31:13], 13'h0});
          m_hi[b][e] = hv;
          m_lo[b][e] = lv;
          sreg_rd(bk, 4'd3, rv);  chk("R3 cause equals high write", rv, hv);
          sreg_rd(bk, 4'd4, rv);  chk("R4 select readback", rv, sel);
          if (e[1:0] == 2'b00 || p == 1) begin
            sreg_rd(bk, 4'd5, rv);  chk("R5 committed low", rv, lv);
            sreg_rd(bk, 4'd6, rv);  chk("R5 committed high from cause", rv, hv);
          end
        end
      end
      // Cross-check after a full pass: each entry read back via select, banks kept apart
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < 64; e += 5) begin
          logic [3:0] bk;
          bk = 4'(b + 1);
          sreg_wr(bk, 4'd4, 32'(e), iv, ia);
          sreg_rd(bk, 4'd6, rv);  chk("R7 read refresh high", rv, m_hi[b][e]);
          sreg_rd(bk, 4'd5, rv);  chk("R7 read refresh low", rv, m_lo[b][e]);
          sreg_rd(bk, 4'd9, rv);  chk("R7 unmapped index zero", rv, 32'h0);
        end
    end

    // Non-MMU banks: writes ignored, reads zero
    sreg_wr(4'd1, 4'd6, 32'h5555_AAAA, iv, ia);
    sreg_wr(4'd1, 4'd4, 32'd7, iv, ia);
    sreg_wr(4'd3, 4'd6, 32'hDEAD_0000, iv, ia);
    chk("R2 bank3 high write no inv", {31'h0, iv}, 32'h0);
    sreg_wr(4'd0, 4'd4, 32'd9, iv, ia);
    sreg_wr(4'd0, 4'd5, 32'hFFFF_FFFF, iv, ia);
    chk("R2 bank0 low write no inv", {31'h0, iv}, 32'h0);
    sreg_rd(4'd1, 4'd3, rv);  chk("R2 cause unchanged by bank3", rv, 32'h5555_AAAA);
    sreg_rd(4'd1, 4'd4, rv);  chk("R2 select unchanged by bank0", rv, 32'd7);
    sreg_rd(4'd1, 4'd5, rv);  chk("R2 entry unchanged by bank0", rv, m_lo[0][7]);
    sreg_rd(4'd0, 4'd4, rv);  chk("R2 bank0 read zero", rv, 32'h0);
    sreg_rd(4'd3, 4'd3, rv);  chk("R2 bank3 read zero", rv, 32'h0);

    // Write priority over read
    sreg_rd(4'd1, 4'd3, rv);
    @(negedge clk);
    bank = 4'd1; sreg = 4'd6; wdata = 32'h0BAD_F00D; wr = 1'b1; rd = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0;
    chk("R9 read dropped on write", rdata, 32'h5555_AAAA);
    sreg_rd(4'd1, 4'd3, rv);  chk("R9 write took effect", rv, 32'h0BAD_F00D);

    // Process ID
    pid_write(32'h0000_0012, fl, fp);
    chk("R8 flush on change", {31'h0, fl}, 32'h1);
    chk("R8 flush tag is old id", {24'h0, fp}, 32'h0);
    pid_write(32'h0000_0012, fl, fp);
    chk("R8 no flush same id", {31'h0, fl}, 32'h0);
    pid_write(32'h0000_7712, fl, fp);
    chk("R8 upper bits ignored", {31'h0, fl}, 32'h0);
    pid_write(32'h0000_0034, fl, fp);
    chk("R8 flush on second change", {31'h0, fl}, 32'h1);
    chk("R8 second flush tag", {24'h0, fp}, 32'h12);
    #1;
    chk("R8 current id updated", {24'h0, flush_pid}, 32'h34);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule